// File: doc/BRIEF.md
# Multichannel Acquisition Sequencer

This block is the digital controller of a multichannel sampling system. The host queues command words, each naming an analog channel and a binary gain step, into a 32-entry command queue. For each command the sequencer routes the channel through the internal or the expansion multiplexer and drives the gain code. It then waits a settling interval whose length grows with the gain above ×8, pulses convert-start to an external 12-bit converter, and waits for the converter's done strobe.

Each 12-bit code is placed into a 16-bit word in one of six statically selected formats: natural binary or two's complement, placed left, right or centred. The word is queued, together with the command word that produced it, in a 32-entry result queue. The host reads results from the head of this queue. It can also see three raw status conditions and an interrupt that is gated by a mask. The sequencer stalls while the command queue is empty or the result queue is full.

Top module: `acq_seq_top`

## Requirements
- R1: After reset, status_o is 3'b100, res_valid_o is 0, conv_o is 0 and cmd_ovf_o is 0. Status bit 2 means the command queue is empty, bit 1 means the result queue is full, and bit 0 means a result is available.
- R2: A command word holds the gain code in bits 2:0 and the channel in bits 7:3. Code n selects gain 2^n. While a command is converted, gain_o shows its gain code.
- R3: conv_o is a one-cycle pulse. It rises exactly P cycles after the cycle in which gain_o and the address outputs take the new command. P is BASE_CYC for gain codes 0 to 3 and BASE_CYC·2^(code−3) for codes 4 to 7.
- R4: adc_done_i is taken only between a convert pulse and the capture of that conversion. At any other time it pushes no result.
- R5: fmt_sel_i selects the format. 000, 001 and 010 give natural binary placed at bits 15:4, 11:0 and 13:2. 100, 101 and 110 give two's complement with the same three placements; the code's MSB is inverted. Unused high bits are 0 in natural binary and copy the sign in two's complement. Unused low bits are always 0.
- R6: The reserved formats 011 and 111 produce the word 16'h0000.
- R7: With diff_mode_i=0, channel bits 3:0 drive int_addr_o. If expand_i=1 and channel bit 4 is 1, then ext_en_o=1, ext_addr_o takes channel bits 3:0 and int_addr_o=4'hF. With diff_mode_i=1, int_addr_o={0,ch[2:0]}. If expand_i=1 and channel bit 3 is 1, then ext_en_o=1, ext_addr_o={0,ch[2:0]} and int_addr_o=4'h7. Otherwise ext_en_o=0 and ext_addr_o=0.
- R8: Results leave in conversion order. res_word_o and res_cmd_o show the head entry while res_valid_o=1, and res_cmd_o is the command that produced the word. res_rd_i removes the head entry.
- R9: The command queue holds 32 words. A write to a full queue is dropped and sets cmd_ovf_o, which stays set until reset.
- R10: While the result queue holds 32 entries, no command is taken and no convert pulse is issued. Conversion resumes once the host reads.
- R11: irq_o is high exactly when a status bit is set whose irq_mask_i bit, at the same position, is also set.
- R12: res_rd_i while the result queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| diff_mode_i | input | 1 | Static: 0 single-ended, 1 differential |
| expand_i | input | 1 | Static: expansion multiplexer fitted |
| fmt_sel_i | input | 3 | Static output format select |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_word_i | input | 8 | Command word {channel, gain code} |
| res_rd_i | input | 1 | Result read strobe |
| res_valid_o | output | 1 | Result queue not empty |
| res_word_o | output | 16 | Formatted result at queue head |
| res_cmd_o | output | 8 | Command word of head result |
| status_o | output | 3 | {cmd empty, result full, result available} |
| irq_mask_i | input | 3 | Interrupt enables, same positions as status_o |
| irq_o | output | 1 | Interrupt request |
| cmd_ovf_o | output | 1 | Sticky command overflow |
| gain_o | output | 3 | Gain code to amplifier |
| int_addr_o | output | 4 | Internal multiplexer address |
| ext_en_o | output | 1 | Expansion multiplexer enable |
| ext_addr_o | output | 4 | Expansion multiplexer address |
| conv_o | output | 1 | Convert-start pulse |
| adc_done_i | input | 1 | Converter done strobe |
| adc_code_i | input | 12 | Converter code, offset binary |

## Verification
Two collisions can fall in the same cycle. The host can write the command queue while the sequencer pops it, and the host can read the result queue while the sequencer pushes a capture. Both are provoked by filling the command queue in back-to-back cycles during active conversions, and by draining a full result queue while the stalled sequencer restarts. The bench judges them by the scoreboard: every result must match, in order, both the command word written and the formatted code the converter model returned. No entry may be lost or duplicated, and the one write made to a full queue must be the only command missing.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int GAIN_W = 3;
  localparam int SEL_W  = 4;
  localparam int CH_W   = SEL_W + 1;
  localparam int CMD_W  = CH_W + GAIN_W;
  localparam int ADC_W  = 12;
  localparam int WORD_W = 16;
  localparam int FMT_W  = 3;
  localparam int STAT_W = 3;
  // codes below this run at the base period
  localparam int FAST_GAINS = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_WAIT} seq_state_e;
  typedef enum logic [1:0] {JUST_LEFT, JUST_RIGHT, JUST_CENTER, JUST_NONE} just_e;

  function automatic int unsigned settle_cycles(int unsigned base, logic [GAIN_W-1:0] g);
    if (int'(g) < FAST_GAINS) return base;
    return base << (int'(g) - FAST_GAINS + 1);
  endfunction
endpackage

// File: rtl/acq_fifo.sv
module acq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/acq_route.sv
module acq_route
  import acq_pkg::*;
(
  input  logic             diff_i,
  input  logic             expand_i,
  input  logic [CH_W-1:0]  ch_i,
  output logic [SEL_W-1:0] int_addr_o,
  output logic             ext_en_o,
  output logic [SEL_W-1:0] ext_addr_o
);
  localparam int PAIR_W = SEL_W - 1;

  always_comb begin
    int_addr_o = '0;
    ext_en_o   = 1'b0;
    ext_addr_o = '0;
    if (!diff_i) begin
      if (expand_i && ch_i[SEL_W]) begin
        ext_en_o   = 1'b1;
        ext_addr_o = ch_i[SEL_W-1:0];
        int_addr_o = '1;
      end else begin
        int_addr_o = ch_i[SEL_W-1:0];
      end
    end else begin
      if (expand_i && ch_i[PAIR_W]) begin
        ext_en_o   = 1'b1;
        ext_addr_o = {1'b0, ch_i[PAIR_W-1:0]};
        int_addr_o = {1'b0, {PAIR_W{1'b1}}};
      end else begin
        int_addr_o = {1'b0, ch_i[PAIR_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/acq_fmt.sv
module acq_fmt
  import acq_pkg::*;
(
  input  logic [FMT_W-1:0]  sel_i,
  input  logic [ADC_W-1:0]  code_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int PAD  = WORD_W - ADC_W;
  localparam int HIGH = PAD / 2;
  localparam int LOW  = PAD - HIGH;

  logic             twos;
  logic             sgn;
  logic [ADC_W-1:0] val;
  just_e            just;

  assign twos = sel_i[FMT_W-1];
  assign val  = twos ? {~code_i[ADC_W-1], code_i[ADC_W-2:0]} : code_i;
  assign sgn  = twos & val[ADC_W-1];

  always_comb begin
    unique case (sel_i[1:0])
      2'b00:   just = JUST_LEFT;
      2'b01:   just = JUST_RIGHT;
      2'b10:   just = JUST_CENTER;
      default: just = JUST_NONE;
    endcase
  end

  always_comb begin
    unique case (just)
      JUST_LEFT:   word_o = {val, {PAD{1'b0}}};
      JUST_RIGHT:  word_o = {{PAD{sgn}}, val};
      JUST_CENTER: word_o = {{HIGH{sgn}}, val, {LOW{1'b0}}};
      default:     word_o = '0;
    endcase
  end
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int BASE_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_avail_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              res_full_i,
  input  logic [SEL_W-1:0]  r_int_i,
  input  logic              r_en_i,
  input  logic [SEL_W-1:0]  r_ext_i,
  input  logic              adc_done_i,
  output logic              cmd_pop_o,
  output logic              res_push_o,
  output logic [CMD_W-1:0]  cur_cmd_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic [SEL_W-1:0]  int_addr_o,
  output logic              ext_en_o,
  output logic [SEL_W-1:0]  ext_addr_o,
  output logic              conv_o
);
  localparam int CW = $clog2(BASE_CYC << 4) + 1;

  seq_state_e        st_q;
  logic [CW-1:0]     cnt_q;
  logic              conv_q;
  logic [GAIN_W-1:0] new_gain;

  assign new_gain   = cmd_i[GAIN_W-1:0];
  assign cmd_pop_o  = (st_q == ST_IDLE) && cmd_avail_i && !res_full_i;
  assign res_push_o = (st_q == ST_WAIT) && adc_done_i;
  assign conv_o     = conv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      conv_q     <= 1'b0;
      cur_cmd_o  <= '0;
      gain_o     <= '0;
      int_addr_o <= '0;
      ext_en_o   <= 1'b0;
      ext_addr_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_pop_o) begin
            cur_cmd_o  <= cmd_i;
            gain_o     <= new_gain;
            int_addr_o <= r_int_i;
            ext_en_o   <= r_en_i;
            ext_addr_o <= r_ext_i;
            cnt_q      <= CW'(settle_cycles(BASE_CYC, new_gain) - 1);
            st_q       <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (cnt_q == '0) begin
            conv_q <= 1'b1;
            st_q   <= ST_WAIT;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WAIT: begin
          conv_q <= 1'b0;
          if (adc_done_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acq_seq_top.sv
module acq_seq_top
  import acq_pkg::*;
#(
  parameter int BASE_CYC  = 8,
  parameter int CMD_DEPTH = 32,
  parameter int RES_DEPTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              diff_mode_i,
  input  logic              expand_i,
  input  logic [FMT_W-1:0]  fmt_sel_i,
  input  logic              cmd_wr_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  input  logic              res_rd_i,
  output logic              res_valid_o,
  output logic [WORD_W-1:0] res_word_o,
  output logic [CMD_W-1:0]  res_cmd_o,
  output logic [STAT_W-1:0] status_o,
  input  logic [STAT_W-1:0] irq_mask_i,
  output logic              irq_o,
  output logic              cmd_ovf_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic [SEL_W-1:0]  int_addr_o,
  output logic              ext_en_o,
  output logic [SEL_W-1:0]  ext_addr_o,
  output logic              conv_o,
  input  logic              adc_done_i,
  input  logic [ADC_W-1:0]  adc_code_i
);
  localparam int RES_W = CMD_W + WORD_W;

  logic              cmd_empty, cmd_full, cmd_pop;
  logic [CMD_W-1:0]  cmd_head;
  logic              res_empty, res_full, res_push;
  logic [RES_W-1:0]  res_head;
  logic [CMD_W-1:0]  cur_cmd;
  logic [WORD_W-1:0] fmt_word;
  logic [SEL_W-1:0]  r_int, r_ext;
  logic              r_en;
  logic              ovf_q;

  acq_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk_i, .rst_ni,
    .push_i (cmd_wr_i),
    .wdata_i(cmd_word_i),
    .pop_i  (cmd_pop),
    .rdata_o(cmd_head),
    .empty_o(cmd_empty),
    .full_o (cmd_full)
  );

  acq_route u_route (
    .diff_i    (diff_mode_i),
    .expand_i  (expand_i),
    .ch_i      (cmd_head[CMD_W-1:GAIN_W]),
    .int_addr_o(r_int),
    .ext_en_o  (r_en),
    .ext_addr_o(r_ext)
  );

  acq_seq #(.BASE_CYC(BASE_CYC)) u_seq (
    .clk_i, .rst_ni,
    .cmd_avail_i(!cmd_empty),
    .cmd_i      (cmd_head),
    .res_full_i (res_full),
    .r_int_i    (r_int),
    .r_en_i     (r_en),
    .r_ext_i    (r_ext),
    .adc_done_i (adc_done_i),
    .cmd_pop_o  (cmd_pop),
    .res_push_o (res_push),
    .cur_cmd_o  (cur_cmd),
    .gain_o     (gain_o),
    .int_addr_o (int_addr_o),
    .ext_en_o   (ext_en_o),
    .ext_addr_o (ext_addr_o),
    .conv_o     (conv_o)
  );

  acq_fmt u_fmt (
    .sel_i (fmt_sel_i),
    .code_i(adc_code_i),
    .word_o(fmt_word)
  );

  acq_fifo #(.WIDTH(RES_W), .DEPTH(RES_DEPTH)) u_res_fifo (
    .clk_i, .rst_ni,
    .push_i (res_push),
    .wdata_i({cur_cmd, fmt_word}),
    .pop_i  (res_rd_i),
    .rdata_o(res_head),
    .empty_o(res_empty),
    .full_o (res_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else if (cmd_wr_i && cmd_full) ovf_q <= 1'b1;
  end

  assign cmd_ovf_o   = ovf_q;
  assign res_valid_o = !res_empty;
  assign res_word_o  = res_head[WORD_W-1:0];
  assign res_cmd_o   = res_head[RES_W-1:WORD_W];
  assign status_o    = {cmd_empty, res_full, !res_empty};
  assign irq_o       = |(status_o & irq_mask_i);
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk
  import acq_pkg::*;
#(
  parameter int BASE_CYC = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_o,
  input logic [GAIN_W-1:0] gain_o,
  input logic              cmd_pop,
  input logic              cmd_wr_i,
  input logic              cmd_full,
  input logic              cmd_ovf_o,
  input logic              res_push,
  input logic              res_full,
  input logic [STAT_W-1:0] status_o,
  input logic [STAT_W-1:0] irq_mask_i,
  input logic              irq_o
);
  int unsigned since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= 0;
    else if (cmd_pop) since_q <= 0;
    else since_q <= since_q + 1;
  end

  AST_CONV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |=> !conv_o); // R3
  AST_SETTLE_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> (since_q == settle_cycles(BASE_CYC, gain_o))); // R3
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_full) |=> cmd_ovf_o); // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ovf_o |=> cmd_ovf_o); // R9
  AST_NO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_full |-> !res_push); // R10
  AST_NO_POP_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_full |-> !cmd_pop); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mask_i == '0) |-> !irq_o); // R11
  AST_EMPTY_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] |-> !cmd_pop); // R11
endmodule

bind acq_seq_top acq_seq_chk #(.BASE_CYC(BASE_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .conv_o    (conv_o),
  .gain_o    (gain_o),
  .cmd_pop   (cmd_pop),
  .cmd_wr_i  (cmd_wr_i),
  .cmd_full  (cmd_full),
  .cmd_ovf_o (cmd_ovf_o),
  .res_push  (res_push),
  .res_full  (res_full),
  .status_o  (status_o),
  .irq_mask_i(irq_mask_i),
  .irq_o     (irq_o)
);

// File: tb/acq_seq_top_tb_top.sv
`timescale 1ns/1ps
module acq_seq_top_tb_top;
  localparam int BASE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        diff_mode = 0, expand = 0;
  logic [2:0]  fmt_sel = 0, irq_mask = 0;
  logic        cmd_wr = 0;
  logic [7:0]  cmd_word = 0;
  logic        rd_mon = 0, rd_force = 0, done_mdl = 0, done_force = 0;
  logic [11:0] code_mdl = 0, code_force = 0;
  wire         res_rd   = rd_mon | rd_force;
  wire         adc_done = done_mdl | done_force;
  wire [11:0]  adc_code = done_force ? code_force : code_mdl;

  logic        res_valid, irq, ovf, ext_en, conv;
  logic [15:0] res_word;
  logic [7:0]  res_cmd;
  logic [2:0]  status, gain;
  logic [3:0]  int_addr, ext_addr;

  acq_seq_top #(.BASE_CYC(BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .diff_mode_i(diff_mode), .expand_i(expand),
    .fmt_sel_i(fmt_sel), .cmd_wr_i(cmd_wr), .cmd_word_i(cmd_word), .res_rd_i(res_rd),
    .res_valid_o(res_valid), .res_word_o(res_word), .res_cmd_o(res_cmd),
    .status_o(status), .irq_mask_i(irq_mask), .irq_o(irq), .cmd_ovf_o(ovf),
    .gain_o(gain), .int_addr_o(int_addr), .ext_en_o(ext_en), .ext_addr_o(ext_addr),
    .conv_o(conv), .adc_done_i(adc_done), .adc_code_i(adc_code)
  );

  int    checks = 0, errors = 0, conv_count = 0;
  bit    finished = 0, rd_en = 0, adc_busy = 0;
  string cur_req = "R8";
  logic [7:0]  cmd_q[$];
  logic [23:0] exp_q[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bench_period(logic [2:0] g);
    int p = BASE;
    for (int i = 4; i <= int'(g); i++) p = p * 2;
    return p;
  endfunction

  function automatic logic [15:0] exp_word(logic [2:0] f, logic [11:0] c);
    logic [15:0] z, sx;
    z  = {4'b0, c};
    sx = {{4{~c[11]}}, ~c[11], c[10:0]};
    case (f)
      3'd0: return z << 4;
      3'd1: return z;
      3'd2: return z << 2;
      3'd4: return sx << 4;
      3'd5: return sx;
      3'd6: return sx << 2;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [8:0] exp_route(logic d, logic e, logic [4:0] ch);
    if (!d) begin
      if (e && ch[4]) return {4'hF, 1'b1, ch[3:0]};
      return {ch[3:0], 1'b0, 4'h0};
    end
    if (e && ch[3]) return {4'h7, 1'b1, 1'b0, ch[2:0]};
    return {1'b0, ch[2:0], 1'b0, 4'h0};
  endfunction

  function automatic logic [11:0] pick(int k);
    case (k % 5)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'h800;
      3: return 12'h7FF;
      default: return 12'(k * 12'h2A7) ^ 12'h5C3;
    endcase
  endfunction

  task automatic send(logic [4:0] ch, logic [2:0] g);
    cmd_q.push_back({ch, g});
    cmd_wr = 1; cmd_word = {ch, g};
    @(negedge clk);
    cmd_wr = 0;
  endtask

  task automatic send_drop(logic [4:0] ch, logic [2:0] g);
    cmd_wr = 1; cmd_word = {ch, g};
    @(negedge clk);
    cmd_wr = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((cmd_q.size() != 0 || exp_q.size() != 0 || adc_busy || res_valid) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  // converter model: checks routing at the pulse, returns a code later
  initial begin : adc_model
    int k;
    logic [7:0]  c;
    logic [11:0] d;
    k = 0;
    forever begin
      @(negedge clk);
      if (conv === 1'b1) begin
        conv_count++;
        adc_busy = 1;
        if (cmd_q.size() == 0) chk("R2", "conversion without command", 1, 0);
        else begin
          c = cmd_q.pop_front();
          chk("R2", "gain code at pulse", gain, c[2:0]);
          chk("R7", "routing", {int_addr, ext_en, ext_addr}, exp_route(diff_mode, expand, c[7:3]));
          d = pick(k);
          k++;
          @(negedge clk);
          chk("R3", "pulse width", conv, 0);
          @(negedge clk);
          code_mdl = d; done_mdl = 1;
          exp_q.push_back({c, exp_word(fmt_sel, d)});
          @(negedge clk);
          done_mdl = 0;
        end
        adc_busy = 0;
      end
    end
  end

  // settle window measured from a visible gain change
  initial begin : timing_mon
    int cyc, t_chg;
    bit armed;
    logic [2:0] last_g;
    cyc = 0; t_chg = 0; armed = 0; last_g = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        last_g = 0; armed = 0;
      end else begin
        if (gain !== last_g) begin
          last_g = gain; t_chg = cyc; armed = 1;
        end
        if (conv === 1'b1 && armed) begin
          chk("R3", "settle cycles", 32'(cyc - t_chg), 32'(bench_period(gain)));
          armed = 0;
        end
      end
    end
  end

  // scoreboard monitor
  initial begin : monitor
    logic [23:0] e;
    forever begin
      @(negedge clk);
      if (rd_mon) rd_mon = 0;
      else if (rd_en && res_valid) begin
        if (exp_q.size() == 0) chk("R8", "unexpected result", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(cur_req, "result {cmd,word}", {res_cmd, res_word}, e);
        end
        rd_mon = 1;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    chk("R1", "status in reset", status, 3'b100);
    chk("R1", "valid in reset", res_valid, 0);
    chk("R1", "conv in reset", conv, 0);
    chk("R1", "overflow in reset", ovf, 0);
    rst_n = 1;
    @(negedge clk);
    irq_mask = 3'b100; #1;
    chk("R11", "irq on cmd empty", irq, 1);
    irq_mask = 3'b011; #1;
    chk("R11", "irq masked off", irq, 0);

    // stray done strobe
    code_force = 12'hABC; done_force = 1;
    @(negedge clk);
    done_force = 0;
    repeat (4) @(negedge clk);
    chk("R4", "no result from stray done", res_valid, 0);
    chk("R4", "no conversion", conv_count, 0);

    // read of empty result queue
    rd_force = 1;
    @(negedge clk);
    rd_force = 0;
    @(negedge clk);
    chk("R12", "status after empty read", status, 3'b100);

    // gain sweep, every step differs from the previous one
    rd_en = 1; cur_req = "R8";
    send(5'd3, 3'd4); send(5'd9, 3'd0); send(5'd12, 3'd5); send(5'd1, 3'd1);
    send(5'd15, 3'd7); send(5'd6, 3'd2); send(5'd0, 3'd6); send(5'd10, 3'd3);
    drain();

    // every format code, boundary codes each time
    for (int f = 0; f < 8; f++) begin
      fmt_sel = 3'(f);
      cur_req = (f == 3 || f == 7) ? "R6" : "R5";
      for (int j = 0; j < 5; j++) send(5'(j * 3 + f), 3'(j % 4));
      drain();
    end

    // routing modes
    cur_req = "R7";
    fmt_sel = 3'b101;
    for (int m = 0; m < 4; m++) begin
      {expand, diff_mode} = 2'(m);
      for (int j = 0; j < 8; j++) send(5'((j * 4 + (j >> 1)) % 32), 3'(j % 3));
      drain();
    end

    // stall on full result queue, then command overflow
    expand = 0; diff_mode = 0; fmt_sel = 3'b001;
    rd_en = 0; cur_req = "R10";
    for (int j = 0; j < 34; j++) send(5'(j), 3'd0);
    repeat (700) @(negedge clk);
    chk("R10", "status when result full", status, 3'b011);
    n = conv_count;
    repeat (100) @(negedge clk);
    chk("R10", "no conversion while full", conv_count, n);
    irq_mask = 3'b010; #1;
    chk("R11", "irq on result full", irq, 1);
    irq_mask = 3'b100; #1;
    chk("R11", "irq cmd empty masked", irq, 0);
    irq_mask = 3'b000;
    for (int j = 0; j < 30; j++) send(5'(j + 1), 3'd1);
    chk("R9", "no overflow at 32", ovf, 0);
    send_drop(5'd31, 3'd7);
    chk("R9", "overflow on write to full", ovf, 1);
    rd_en = 1; cur_req = "R9";
    drain();
    chk("R9", "overflow sticky", ovf, 1);
    chk("R11", "status after drain", status, 3'b100);
    chk("R8", "scoreboard empty", exp_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule